// File: doc/BRIEF.md
# UART Modem Handshake Monitor

This block handles the handshake lines of a serial port. It drives two control outputs toward the modem and watches four status inputs: clear-to-send, data-set-ready, ring and carrier-detect. Each input passes through a synchroniser. Each input has a sticky change flag. A flag is set by any transition on clear-to-send, data-set-ready or carrier-detect. On the ring input, only a high-to-low transition sets the flag. An interrupt is raised while any flag is set and the interrupt enable is on.

The host uses two single-cycle strobes. A control write loads the output drive bits, two spare bits, the loop enable and the interrupt enable. A status read returns the four change flags and the four effective input levels, then clears the flags. In loop mode the external outputs are held low. The four status inputs are then fed from the control register instead of the pins, so software can test the whole change-detection path without a modem attached.

Top module: `hs_modem_monitor`

## Requirements
- R1: After reset, `line_out` is 0, `irq` is 0 and the four change flags (`stat_rdata[3:0]`) are 0.
- R2: With the loop bit (`ctrl_wdata[4]`) clear, a control write makes `line_out` equal to `ctrl_wdata[1:0]` from the next clock edge on.
- R3: Status index 0 is clear-to-send, 1 is data-set-ready, 2 is ring and 3 is carrier-detect. For indices 0, 1 and 3, a change in either direction sets the matching flag. The flag becomes visible after the third rising clock edge following the pin change.
- R4: The ring flag (index 2) is set only by a 1-to-0 transition of the effective ring level. A 0-to-1 transition leaves the flag unchanged.
- R5: Flags stay set until a status read. `stat_rdata` is {effective levels[3:0], flags[3:0]}, and it is valid in the cycle `stat_rd` is high. All flags clear at the edge that ends the read cycle.
- R6: If an edge is detected at the same clock edge that ends a read, that flag is set rather than cleared.
- R7: `irq` is high exactly when the interrupt enable (`ctrl_wdata[5]` at the last write) is 1 and at least one flag is set.
- R8: With the loop bit set, `line_out` is held at 0 and the effective levels are {ctrl[3], ctrl[2], ctrl[1], ctrl[0]} for indices {3,2,1,0}. The pins `line_in` have no effect in this mode.
- R9: `stat_rdata[7:4]` shows the effective levels: the synchronised pins in normal mode, the control bits in loop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 6 | Control: [1:0] drive, [3:2] spare, [4] loop, [5] irq enable |
| stat_rd | input | 1 | Status read strobe, clears flags |
| stat_rdata | output | 8 | {levels[3:0], flags[3:0]} |
| line_in | input | 4 | Status pins, index order per R3, active high |
| line_out | output | 2 | Control outputs to the modem |
| irq | output | 1 | Modem-status interrupt |

## Verification
The hardest case to reach is an edge detected at the very edge that clears the flags on a read (R6). The pin change has to be timed two cycles before the read so that it lands exactly on the clearing edge. The bench schedules this case directly with negedge-counted delays. It also reaches ring edges in both directions and loop-mode transitions through the control register. Random mixes of pin changes, control writes and reads cover the remaining interleavings.

// File: rtl/hs_pkg.sv
package hs_pkg;
    localparam int HS_N_IN  = 4;
    localparam int HS_N_OUT = 2;
    localparam int HS_RING_IDX = 2;
    localparam int HS_CTRL_W = 6;
    localparam logic [HS_N_IN-1:0] HS_TRAIL_MASK = HS_N_IN'(1) << HS_RING_IDX;

    typedef struct packed {
        logic                irq_en;
        logic                loop_en;
        logic [1:0]          spare;
        logic [HS_N_OUT-1:0] drive;
    } hs_ctrl_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stage;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stage[i] = st_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stage[STAGES-1];
endmodule

// File: rtl/hs_change_flags.sv
module hs_change_flags #(
    parameter int           W          = 4,
    parameter logic [W-1:0] TRAIL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         clr,
    output logic [W-1:0] flags,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] flags;
    } flg_t;

    flg_t fl_d, fl_q;
    logic [W-1:0] edge_hit;

    for (genvar g = 0; g < W; g++) begin : g_edge
        if (TRAIL_MASK[g]) begin : g_fall
            assign edge_hit[g] = fl_q.prev[g] & ~lvl[g];
        end else begin : g_any
            assign edge_hit[g] = fl_q.prev[g] ^ lvl[g];
        end
    end

    always_comb begin
        fl_d = fl_q;
        fl_d.prev  = lvl;
        fl_d.flags = (fl_q.flags & ~{W{clr}}) | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags = fl_q.flags;
    assign prev  = fl_q.prev;
endmodule

// File: rtl/hs_modem_monitor.sv
module hs_modem_monitor
    import hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_wr,
    input  logic [HS_CTRL_W-1:0]   ctrl_wdata,
    input  logic                   stat_rd,
    output logic [2*HS_N_IN-1:0]   stat_rdata,
    input  logic [HS_N_IN-1:0]     line_in,
    output logic [HS_N_OUT-1:0]    line_out,
    output logic                   irq
);
    typedef struct packed {
        hs_ctrl_t ctrl;
    } top_t;

    top_t tp_d, tp_q;
    logic [HS_N_IN-1:0] lvl_sync;
    logic [HS_N_IN-1:0] lvl_eff;
    logic [HS_N_IN-1:0] lvl_prev;
    logic [HS_N_IN-1:0] chg_flags;

    hs_sync #(.W(HS_N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .dout (lvl_sync)
    );

    // loop: drive bits feed indices 0/1, spare bits feed ring (2) and carrier (3)
    always_comb begin
        if (tp_q.ctrl.loop_en) lvl_eff = {tp_q.ctrl.spare[1], tp_q.ctrl.spare[0], tp_q.ctrl.drive};
        else                   lvl_eff = lvl_sync;
    end

    hs_change_flags #(.W(HS_N_IN), .TRAIL_MASK(HS_TRAIL_MASK)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl_eff),
        .clr  (stat_rd),
        .flags(chg_flags),
        .prev (lvl_prev)
    );

    always_comb begin
        tp_d = tp_q;
        if (ctrl_wr) tp_d.ctrl = hs_ctrl_t'(ctrl_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign line_out   = tp_q.ctrl.loop_en ? '0 : tp_q.ctrl.drive;
    assign irq        = tp_q.ctrl.irq_en & (|chg_flags);
    assign stat_rdata = {lvl_eff, chg_flags};
endmodule

// File: rtl/hs_modem_monitor_chk.sv
module hs_modem_monitor_chk
    import hs_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctrl_wr,
    input logic [HS_CTRL_W-1:0] ctrl_wdata,
    input logic                 stat_rd,
    input logic [HS_N_IN-1:0]   flags,
    input logic [HS_N_IN-1:0]   lvl_eff,
    input logic [HS_N_IN-1:0]   lvl_prev,
    input logic [HS_N_OUT-1:0]  line_out,
    input logic                 irq
);
    assert_drive_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_wdata[4]) |=> line_out == $past(ctrl_wdata[1:0]));

    assert_loop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[4]) |=> (line_out == '0 && lvl_eff == $past(ctrl_wdata[3:0])));

    assert_any_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_eff[0] != lvl_prev[0]) || (lvl_eff[1] != lvl_prev[1]) || (lvl_eff[3] != lvl_prev[3]))
        |=> ((flags & 4'b1011) & $past((lvl_eff ^ lvl_prev) & 4'b1011)) == $past((lvl_eff ^ lvl_prev) & 4'b1011));

    assert_ring_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[HS_RING_IDX] && !(lvl_prev[HS_RING_IDX] && !lvl_eff[HS_RING_IDX])) |=> !flags[HS_RING_IDX]);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> (flags & $past(flags)) == $past(flags));

    assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && lvl_eff == lvl_prev) |=> flags == '0);

    assert_irq_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flags != '0);

    assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_wdata[5]) |=> !irq);
endmodule

bind hs_modem_monitor hs_modem_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_wdata(ctrl_wdata),
    .stat_rd   (stat_rd),
    .flags     (stat_rdata[3:0]),
    .lvl_eff   (lvl_eff),
    .lvl_prev  (lvl_prev),
    .line_out  (line_out),
    .irq       (irq)
);

// File: tb/hs_modem_monitor_bench.sv
module hs_modem_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [5:0] ctrl_wdata = '0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic [3:0] line_in = '0;
    logic [1:0] line_out;
    logic       irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [5:0] m_ctrl = '0;
    logic [3:0] m_pins = '0;
    logic [3:0] m_prev = '0;
    logic [3:0] m_flags = '0;

    always #5 clk = ~clk;

    hs_modem_monitor u_hs_modem_monitor (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .stat_rd(stat_rd), .stat_rdata(stat_rdata), .line_in(line_in),
        .line_out(line_out), .irq(irq)
    );

    function automatic logic [3:0] eff_of(logic [5:0] c, logic [3:0] p);
        return c[4] ? c[3:0] : p;
    endfunction

    function automatic logic [3:0] edges_of(logic [3:0] pv, logic [3:0] nw);
        return ((pv ^ nw) & 4'b1011) | (pv & ~nw & 4'b0100);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step();
        logic [3:0] nw = eff_of(m_ctrl, m_pins);
        m_flags = m_flags | edges_of(m_prev, nw);
        m_prev  = nw;
    endtask

    task automatic check_outs();
        check("R2/R8 line_out", {6'd0, line_out}, {6'd0, m_ctrl[4] ? 2'b00 : m_ctrl[1:0]});
        check("R7 irq", {7'd0, irq}, {7'd0, m_ctrl[5] & (|m_flags)});
    endtask

    task automatic set_pins(logic [3:0] v);
        @(negedge clk);
        line_in = v;
        m_pins = v;
        repeat (4) @(negedge clk);
        model_step();
        check_outs();
    endtask

    task automatic wr_ctrl(logic [5:0] v);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
        m_ctrl = v;
        check("R2/R8 line_out after write", {6'd0, line_out}, {6'd0, v[4] ? 2'b00 : v[1:0]});
        repeat (2) @(negedge clk);
        model_step();
        check_outs();
    endtask

    task automatic rd_stat(string req);
        @(negedge clk);
        check(req, stat_rdata, {eff_of(m_ctrl, m_pins), m_flags});
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        m_flags = '0;
        check("R5 flags cleared", {4'd0, stat_rdata[3:0]}, 8'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check("R1 reset flags", stat_rdata, 8'h00);
        check("R1 reset line_out", {6'd0, line_out}, 8'd0);
        check("R1 reset irq", {7'd0, irq}, 8'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: drive outputs, irq enabled
        wr_ctrl(6'b10_00_11);
        wr_ctrl(6'b10_00_10);
        // R3: both directions on index 0 and 3
        set_pins(4'b1001);
        rd_stat("R3 rising on 0/3");
        set_pins(4'b0000);
        rd_stat("R3 falling on 0/3");
        // R4: ring rising does not set, falling does
        set_pins(4'b0100);
        rd_stat("R4 ring rise ignored");
        set_pins(4'b0000);
        rd_stat("R4 ring fall flagged");
        // R5: sticky across several changes
        set_pins(4'b0010);
        set_pins(4'b0011);
        rd_stat("R5 sticky accumulate");
        // R7: enable off hides flags
        wr_ctrl(6'b00_00_01);
        set_pins(4'b1011);
        check("R7 irq masked", {7'd0, irq}, 8'd0);
        rd_stat("R9 levels shown");
        wr_ctrl(6'b10_00_01);
        // R6: edge lands on the clearing edge
        @(negedge clk);
        line_in = 4'b0011;
        m_pins = 4'b0011;
        @(negedge clk);
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R6 set wins over clear", {4'd0, stat_rdata[3:0]}, 8'h08);
        m_prev = 4'b0011;
        m_flags = 4'b1000;
        rd_stat("R6 flag readback");
        // R8: loop mode, pins ignored
        wr_ctrl(6'b11_11_11);
        rd_stat("R8 loop levels");
        set_pins(4'b1100);
        rd_stat("R8 pins ignored in loop");
        wr_ctrl(6'b11_10_11);
        rd_stat("R8 loop ring fall");
        wr_ctrl(6'b10_00_00);
        rd_stat("R9 back to pins");

        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 2);
            if (op == 0)      set_pins(4'($urandom));
            else if (op == 1) wr_ctrl(6'($urandom));
            else              rd_stat("R3/R4/R5/R8 random read");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule